// File: doc/BRIEF.md
# PHY Basic Mode Control Register

This block holds the basic mode control word of a 10/100 Ethernet PHY. It answers at one management address, and a simple register port reaches it: address, write data, write strobe and combinational read data. Its outputs go to the rest of the PHY: a soft reset, MII loopback, the forced speed and duplex, the auto-negotiation enable, and a one-cycle start strobe for the negotiation engine.

Every reset sequence samples a two-pin configuration strap and loads the control defaults from it. This covers both the power-on reset and a software-requested one. While a sequence runs, the reset bit reads back as set. When auto-negotiation is active, it overrides the forced speed and duplex bits. When the strap disables negotiation, software must write the enable bit to zero before a later write of one takes effect. The register's own loopback bit masks a loopback selection that arrives from a secondary register.

Top module: `phy_bmc_top`

## Requirements
- R1: While rst_n is low, soft_rst_o is high. It falls at the RST_CYCLES-th rising edge after rst_n is released. Once it falls, the control word reads with bit 15 = 0.
- R2: A write at address REG_ADDR with bit 15 = 1 raises soft_rst_o at the edge that takes the write. soft_rst_o stays high for RST_CYCLES cycles, and read-data bit 15 equals soft_rst_o. While the sequence runs, mii_loop_o and an_en_o are 0, and the sequence returns all control bits to their strap defaults.
- R3: The strap pins are sampled only during a reset sequence. Strap changes at any other time have no effect. Decode of strap[1:0]: 01 sets negotiation off and speed bit 0; 10 sets negotiation off and speed bit 1; 00 and 11 set negotiation on and speed bit 1. The loopback and duplex bits always default to 0.
- R4: Bit 14 drives mii_loop_o and defaults to 0.
- R5: While bit 14 is set, aux_lb_o is 00. Otherwise aux_lb_o equals aux_lb_i.
- R6: While an_en_o is 0, speed100_o follows bit 13 and full_dpx_o follows bit 8. While an_en_o is 1, they follow hcd_100_i and hcd_fd_i.
- R7: an_en_o is 1 when bit 12 is 1, unless the last reset sequence left negotiation off by strap and no write with bit 12 = 0 has been taken since. In that case, writing 1 leaves an_en_o at 0.
- R8: an_start_o is a one-cycle pulse on each rise of an_en_o.
- R9: The read data has bits 11 to 9 and 7 to 0 at 0, and writes to them are ignored. A read at any other address returns 0, and a write to any other address changes nothing.
- R10: Writes taken while soft_rst_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data (combinational) |
| strap_i | input | 2 | Configuration strap pins |
| aux_lb_i | input | 2 | Loopback select from the secondary register |
| hcd_100_i | input | 1 | Negotiated speed is 100 Mb/s |
| hcd_fd_i | input | 1 | Negotiated duplex is full |
| soft_rst_o | output | 1 | Reset sequence in progress |
| mii_loop_o | output | 1 | MII loopback enable |
| aux_lb_o | output | 2 | Effective secondary loopback select |
| an_en_o | output | 1 | Effective auto-negotiation enable |
| an_start_o | output | 1 | Negotiation start pulse |
| speed100_o | output | 1 | Effective speed is 100 Mb/s |
| full_dpx_o | output | 1 | Effective duplex is full |

## Verification
Some rules are checked on every cycle:
- the start strobe is a single-cycle pulse on a rise of the enable;
- the register's loopback bit masks the secondary loopback;
- the outputs stay quiet during a reset sequence;
- the reset bit reads back the sequence state;
- reserved bits read as zero;
- the forced speed follows the stored bit;
- no sequence runs longer than its cycle count.

Only the bench scenarios can show the rest:
- the exact reset length;
- strap decoding at one reset and re-latching at a later one;
- the clear-then-set unlock of negotiation;
- writes ignored during reset or at a foreign address.

// File: rtl/phy_bmc_pkg.sv
package phy_bmc_pkg;

   localparam int DATA_W   = 16;
   localparam int BIT_RST  = 15;
   localparam int BIT_LOOP = 14;
   localparam int BIT_SPD  = 13;
   localparam int BIT_ANE  = 12;
   localparam int BIT_DPX  = 8;

   typedef struct packed {
      logic an_on;
      logic spd100;
   } strap_dflt_t;

   typedef struct packed {
      logic loop;
      logic spd100;
      logic an_req;
      logic dpx_full;
      logic an_block;
   } ctl_t;

   function automatic strap_dflt_t decode_strap(input logic [1:0] s);
      strap_dflt_t d;
      case (s)
         2'b01:   d = '{an_on: 1'b0, spd100: 1'b0};
         2'b10:   d = '{an_on: 1'b0, spd100: 1'b1};
         default: d = '{an_on: 1'b1, spd100: 1'b1};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/phy_bmc_rstseq.sv
module phy_bmc_rstseq #(
   parameter int RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_LAST;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_LAST;
      end
   end

   assign busy = busy_q;
endmodule

// File: rtl/phy_bmc_strap.sv
module phy_bmc_strap
   import phy_bmc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        capture,
   input  logic [1:0]  strap_pins,
   output strap_dflt_t dflt
);
   logic [1:0] synced;
   logic [1:0] latched_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = strap_pins;
      end else begin : g_sync
         logic [1:0] stage_q [SYNC_STAGES];
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= '0;
               else if (i == 0) stage_q[i] <= strap_pins;
               else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
         end
         assign synced = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latched_q <= '0;
      else if (capture) latched_q <= synced;
   end

   assign dflt = decode_strap(latched_q);
endmodule

// File: rtl/phy_bmc_fields.sv
module phy_bmc_fields
   import phy_bmc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_dflt,
   input  strap_dflt_t dflt,
   input  logic        wr_en,
   input  logic        wr_loop,
   input  logic        wr_spd,
   input  logic        wr_ane,
   input  logic        wr_dpx,
   output ctl_t        ctl
);
   ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '{loop: 1'b0, spd100: 1'b1, an_req: 1'b1, dpx_full: 1'b0, an_block: 1'b0};
      end else if (load_dflt) begin
         ctl_q.loop     <= 1'b0;
         ctl_q.spd100   <= dflt.spd100;
         ctl_q.an_req   <= dflt.an_on;
         ctl_q.dpx_full <= 1'b0;
         ctl_q.an_block <= ~dflt.an_on;
      end else if (wr_en) begin
         ctl_q.loop     <= wr_loop;
         ctl_q.spd100   <= wr_spd;
         ctl_q.an_req   <= wr_ane;
         ctl_q.dpx_full <= wr_dpx;
         if (!wr_ane) ctl_q.an_block <= 1'b0;
      end
   end

   assign ctl = ctl_q;
endmodule

// File: rtl/phy_bmc_top.sv
module phy_bmc_top
   import phy_bmc_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int REG_ADDR    = 0,
   parameter int RST_CYCLES  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [15:0]       reg_wdata,
   input  logic              reg_we,
   output logic [15:0]       reg_rdata,
   input  logic [1:0]        strap_i,
   input  logic [1:0]        aux_lb_i,
   input  logic              hcd_100_i,
   input  logic              hcd_fd_i,
   output logic              soft_rst_o,
   output logic              mii_loop_o,
   output logic [1:0]        aux_lb_o,
   output logic              an_en_o,
   output logic              an_start_o,
   output logic              speed100_o,
   output logic              full_dpx_o
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

   generate
      if (RST_CYCLES < SYNC_STAGES + 2) begin : g_bad_len
         $error("RST_CYCLES must exceed SYNC_STAGES + 1");
      end
      if (REG_ADDR < 0 || REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("REG_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   logic        busy;
   logic        hit;
   logic        soft_go;
   logic        fld_wr;
   logic        an_prev_q;
   strap_dflt_t dflt;
   ctl_t        ctl;

   assign hit     = reg_we && (reg_addr == MY_ADDR);
   assign soft_go = hit && reg_wdata[BIT_RST] && !busy;
   assign fld_wr  = hit && !reg_wdata[BIT_RST] && !busy;

   phy_bmc_rstseq #(.RST_CYCLES(RST_CYCLES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (soft_go),
      .busy  (busy)
   );

   phy_bmc_strap #(.SYNC_STAGES(SYNC_STAGES)) u_strap (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (busy),
      .strap_pins (strap_i),
      .dflt       (dflt)
   );

   phy_bmc_fields u_fields (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_dflt (busy),
      .dflt      (dflt),
      .wr_en     (fld_wr),
      .wr_loop   (reg_wdata[BIT_LOOP]),
      .wr_spd    (reg_wdata[BIT_SPD]),
      .wr_ane    (reg_wdata[BIT_ANE]),
      .wr_dpx    (reg_wdata[BIT_DPX]),
      .ctl       (ctl)
   );

   logic unused_wbits;
   assign unused_wbits = ^{reg_wdata[11:9], reg_wdata[7:0]};

   assign an_en_o = ctl.an_req && !ctl.an_block && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) an_prev_q <= 1'b0;
      else        an_prev_q <= an_en_o;
   end

   assign an_start_o = an_en_o && !an_prev_q;
   assign soft_rst_o = busy;
   assign mii_loop_o = ctl.loop && !busy;
   assign aux_lb_o   = ctl.loop ? 2'b00 : aux_lb_i;
   assign speed100_o = an_en_o ? hcd_100_i : ctl.spd100;
   assign full_dpx_o = an_en_o ? hcd_fd_i  : ctl.dpx_full;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == MY_ADDR) begin
         reg_rdata[BIT_RST]  = busy;
         reg_rdata[BIT_LOOP] = ctl.loop;
         reg_rdata[BIT_SPD]  = ctl.spd100;
         reg_rdata[BIT_ANE]  = ctl.an_req;
         reg_rdata[BIT_DPX]  = ctl.dpx_full;
      end
   end
endmodule

// File: rtl/phy_bmc_chk.sv
module phy_bmc_chk #(
   parameter int ADDR_W     = 5,
   parameter int REG_ADDR   = 0,
   parameter int RST_CYCLES = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [15:0]       reg_rdata,
   input logic              soft_rst_o,
   input logic              mii_loop_o,
   input logic [1:0]        aux_lb_o,
   input logic              an_en_o,
   input logic              an_start_o,
   input logic              speed100_o
);
   localparam int RUN_W = $clog2(RST_CYCLES + 2);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= '0;
      else if (soft_rst_o) run_q <= (run_q == {RUN_W{1'b1}}) ? run_q : run_q + 1'b1;
      else                 run_q <= '0;
   end

   AST_RESET_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> (run_q < RUN_W'(RST_CYCLES)));                                   // R1
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> (!an_en_o && !mii_loop_o));                                      // R2
   AST_RESET_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == MY_ADDR) |-> (reg_rdata[15] == soft_rst_o));                       // R2
   AST_LOOP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      mii_loop_o |-> (aux_lb_o == 2'b00));                                            // R5
   AST_FORCED_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
      (!an_en_o && !soft_rst_o && reg_addr == MY_ADDR) |-> (speed100_o == reg_rdata[13])); // R6
   AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      an_start_o |-> (an_en_o && !$past(an_en_o)));                                   // R8
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      an_start_o |=> !an_start_o);                                                    // R8
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[11:9] == 3'b000) && (reg_rdata[7:0] == 8'h00));                      // R9
endmodule

bind phy_bmc_top phy_bmc_chk #(
   .ADDR_W     (ADDR_W),
   .REG_ADDR   (REG_ADDR),
   .RST_CYCLES (RST_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .soft_rst_o (soft_rst_o),
   .mii_loop_o (mii_loop_o),
   .aux_lb_o   (aux_lb_o),
   .an_en_o    (an_en_o),
   .an_start_o (an_start_o),
   .speed100_o (speed100_o)
);

// File: tb/phy_bmc_top_tb.sv
module phy_bmc_top_tb;
   localparam int RSTC = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_rdata;
   logic [1:0]  strap_i = 2'b00;
   logic [1:0]  aux_lb_i = 2'b10;
   logic        hcd_100_i = 1'b0;
   logic        hcd_fd_i = 1'b1;
   logic        soft_rst_o, mii_loop_o, an_en_o, an_start_o, speed100_o, full_dpx_o;
   logic [1:0]  aux_lb_o;

   always #4 clk = ~clk;

   phy_bmc_top #(.RST_CYCLES(RSTC)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .strap_i(strap_i), .aux_lb_i(aux_lb_i),
      .hcd_100_i(hcd_100_i), .hcd_fd_i(hcd_fd_i), .soft_rst_o(soft_rst_o),
      .mii_loop_o(mii_loop_o), .aux_lb_o(aux_lb_o), .an_en_o(an_en_o),
      .an_start_o(an_start_o), .speed100_o(speed100_o), .full_dpx_o(full_dpx_o)
   );

   typedef enum int {S_RDATA, S_SRST, S_LOOP, S_AUX, S_ANEN, S_ANST, S_SPD, S_DPX} sig_e;
   typedef struct {
      sig_e        sig;
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 0;

   function automatic logic [15:0] observe(sig_e s);
      case (s)
         S_RDATA: return reg_rdata;
         S_SRST:  return {15'd0, soft_rst_o};
         S_LOOP:  return {15'd0, mii_loop_o};
         S_AUX:   return {14'd0, aux_lb_o};
         S_ANEN:  return {15'd0, an_en_o};
         S_ANST:  return {15'd0, an_start_o};
         S_SPD:   return {15'd0, speed100_o};
         default: return {15'd0, full_dpx_o};
      endcase
   endfunction

   // monitor: judges expectations pushed before an edge, 2 ns after that edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = q.pop_front();
            act = observe(it.sig);
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s %s: actual %h expected %h", it.req, it.sig.name(), act, it.exp);
            end
         end
      end
   end

   task automatic expect_after(sig_e s, logic [15:0] e, string r);
      item_t it;
      it.sig = s; it.exp = e; it.req = r;
      q.push_back(it);
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic put_wr(logic [4:0] a, logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
   endtask

   task automatic end_wr();
      step();
      reg_we = 1'b0; reg_addr = 5'd0; reg_wdata = '0;
   endtask

   initial begin
      repeat (3) step();
      expect_after(S_SRST, 16'd1, "R1");
      step();
      rst_n = 1'b1;
      // power-on sequence: high for RSTC-1 more edges, low at the RSTC-th
      for (int i = 0; i < RSTC - 1; i++) begin
         expect_after(S_SRST, 16'd1, "R1");
         step();
      end
      expect_after(S_SRST,  16'd0,    "R1");
      expect_after(S_RDATA, 16'h3000, "R1");
      expect_after(S_LOOP,  16'd0,    "R4");
      expect_after(S_AUX,   16'd2,    "R5");
      expect_after(S_ANEN,  16'd1,    "R3");
      expect_after(S_ANST,  16'd1,    "R8");
      expect_after(S_SPD,   16'd0,    "R6");
      expect_after(S_DPX,   16'd1,    "R6");
      step();
      expect_after(S_ANST, 16'd0, "R8");
      step();

      // loopback on, negotiation off, forced 10 half
      put_wr(5'd0, 16'h4000);
      expect_after(S_LOOP,  16'd1,    "R4");
      expect_after(S_AUX,   16'd0,    "R5");
      expect_after(S_ANEN,  16'd0,    "R6");
      expect_after(S_SPD,   16'd0,    "R6");
      expect_after(S_DPX,   16'd0,    "R6");
      expect_after(S_RDATA, 16'h4000, "R4");
      end_wr();

      // forced 100 full, loopback off
      put_wr(5'd0, 16'h2100);
      expect_after(S_LOOP,  16'd0,    "R4");
      expect_after(S_AUX,   16'd2,    "R5");
      expect_after(S_SPD,   16'd1,    "R6");
      expect_after(S_DPX,   16'd1,    "R6");
      expect_after(S_RDATA, 16'h2100, "R6");
      end_wr();

      // all ones except reset: reserved bits dropped, negotiation rises
      put_wr(5'd0, 16'h7FFF);
      expect_after(S_RDATA, 16'h7100, "R9");
      expect_after(S_ANEN,  16'd1,    "R7");
      expect_after(S_ANST,  16'd1,    "R8");
      expect_after(S_SPD,   16'd0,    "R6");
      expect_after(S_LOOP,  16'd1,    "R4");
      end_wr();
      expect_after(S_ANST, 16'd0, "R8");
      step();

      // foreign address
      put_wr(5'd5, 16'h0000);
      expect_after(S_RDATA, 16'h0000, "R9");
      expect_after(S_LOOP,  16'd1,    "R9");
      end_wr();
      expect_after(S_RDATA, 16'h7100, "R9");
      step();

      // soft reset with new strap 01
      strap_i = 2'b01;
      put_wr(5'd0, 16'h8000);
      expect_after(S_SRST, 16'd1, "R2");
      expect_after(S_LOOP, 16'd0, "R2");
      expect_after(S_ANEN, 16'd0, "R2");
      end_wr();
      put_wr(5'd0, 16'h6100);
      expect_after(S_SRST, 16'd1, "R10");
      end_wr();
      for (int i = 0; i < RSTC - 2; i++) begin
         expect_after(S_SRST, 16'd1, "R2");
         step();
      end
      expect_after(S_SRST,  16'd0,    "R2");
      expect_after(S_RDATA, 16'h0000, "R10");
      expect_after(S_ANEN,  16'd0,    "R3");
      expect_after(S_SPD,   16'd0,    "R3");
      step();

      // negotiation locked until a clear write
      put_wr(5'd0, 16'h1000);
      expect_after(S_ANEN,  16'd0,    "R7");
      expect_after(S_ANST,  16'd0,    "R7");
      expect_after(S_RDATA, 16'h1000, "R7");
      end_wr();
      put_wr(5'd0, 16'h0000);
      expect_after(S_ANEN, 16'd0, "R7");
      end_wr();
      put_wr(5'd0, 16'h1000);
      expect_after(S_ANEN, 16'd1, "R7");
      expect_after(S_ANST, 16'd1, "R8");
      expect_after(S_SPD,  16'd0, "R6");
      end_wr();
      expect_after(S_ANST, 16'd0, "R8");
      step();

      // strap change outside a sequence is ignored, then re-latched by soft reset
      strap_i = 2'b10;
      repeat (5) step();
      expect_after(S_RDATA, 16'h1000, "R3");
      expect_after(S_ANEN,  16'd1,    "R3");
      step();
      put_wr(5'd0, 16'h8000);
      end_wr();
      for (int i = 0; i < RSTC - 1; i++) step();
      expect_after(S_SRST,  16'd0,    "R2");
      expect_after(S_RDATA, 16'h2000, "R3");
      expect_after(S_ANEN,  16'd0,    "R3");
      expect_after(S_SPD,   16'd1,    "R3");
      step();
      step();
      step();

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule